// File: doc/BRIEF.md
# OTP Trim Programming Sequencer

This block decodes a stream of qualified programming events (a mid-level pulse, a high-level pulse and a long blow pulse, each a one-cycle strobe) into the selections needed to trim a sensor's one-time-programmable fuse bank. The events are counted between high-pulse delimiters. The first counted group picks an operating mode: blow, try or read. A later group picks one of four parameter registers. After that the block enters an addressing phase. In this phase the same mid pulses do different things by mode. In try mode they step a temporary binary code. In blow mode they move a one-hot fuse address. In read mode they advance a serial read pointer.

The fuses themselves are kept outside the block. In blow mode the sequencer issues a single blow request for the addressed fuse and then stops accepting events. In read mode it takes back the value of the fuse under the read pointer and turns it into a three-level read indication. A lock fuse input suppresses any further blow request. A malformed key count parks the machine in a fault state. The active-low reset stands for a supply power cycle and clears every temporary value.

Top module: `trimProgSeq`

## Requirements
- R1: After reset, selMode, selReg, tryCode, blowAddr, readPtr, readValid, readLevel, blowReq and faultIdle are all zero. Mid pulses that arrive before the first high pulse have no effect on the later mode count.
- R2: One high pulse opens mode selection. The number of mid pulses before the next high pulse sets selMode: 1 means blow, 2 means try, 3 means read. A second high pulse then opens parameter selection.
- R3: In parameter selection, the number of mid pulses before the closing high pulse sets selReg to 1 to 4, and the machine enters addressing. A high pulse during addressing returns to parameter selection. selReg keeps its last value until the next selection.
- R4: In try mode, each mid pulse during addressing adds one to the selected register's code, which is shown on tryCode. The code saturates at 2^CODE_W-1. Each register keeps its own tried code while other registers are visited, until reset.
- R5: In blow mode, blowAddr is 1 (bit 0) on entry to addressing. Each mid pulse shifts it left by one, and it stays at bit BLOW_W-1 once it gets there. blowAddr is zero whenever the machine is not in blow-mode addressing.
- R6: In blow-mode addressing, a blow pulse makes blowReq high for exactly one cycle, the cycle after the pulse is sampled. After that, every event is ignored until reset.
- R7: When lockFuse is high at the edge where the blow pulse is sampled, blowReq stays low. The machine still stops accepting events, and read mode remains usable after reset.
- R8: In read mode, readPtr is 0 and readValid is 1 on entry to addressing. Each mid pulse advances readPtr by one, up to READ_BITS-1, where it stays.
- R9: readLevel is a step count: 0 outside read mode, 1 while read mode is selected but not addressing, and during read addressing 2 when fuseBit is 1 and 0 when fuseBit is 0.
- R10: Register 3 can be selected only in read mode. Selecting it in blow or try mode sends the machine to the fault state.
- R11: Any of these sends the machine to the fault state: a mode count of 0 or above 3, a register count of 0 or above 4, or a mid pulse between the two high pulses that follow mode selection. In the fault state faultIdle is 1, all events are ignored, and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset (power cycle) |
| midPulse | input | 1 | Qualified mid-level pulse event |
| highPulse | input | 1 | Qualified high-level pulse event |
| blowPulse | input | 1 | Qualified blow pulse event |
| lockFuse | input | 1 | Lock fuse state from fuse storage |
| fuseBit | input | 1 | Fuse value at readPtr from fuse storage |
| selMode | output | 2 | 0 none, 1 blow, 2 try, 3 read |
| selReg | output | 3 | Selected register 1 to 4, 0 when none |
| tryCode | output | CODE_W | Tried code of the selected register |
| blowAddr | output | BLOW_W | One-hot fuse address in blow addressing |
| readPtr | output | PTR_W | Serial read pointer |
| readValid | output | 1 | Read addressing active |
| readLevel | output | 2 | Read indication in steps |
| blowReq | output | 1 | One-cycle fuse blow request |
| faultIdle | output | 1 | Fault state reached |

## Verification
The bench builds the block with CODE_W=3, BLOW_W=4 and READ_BITS=5. With these values, try-code saturation, the one-hot address stopping at its top bit and the read pointer stopping at its last bit each take only a few pulses. The bench drives a fixed fuse pattern on fuseBit, indexed by readPtr, so that readout shows both the blown level and the intact level. Each fault path is run after its own reset, with events applied afterward to show that the fault state holds.

// File: rtl/trimSeqPkg.sv
package trimSeqPkg;
  typedef enum logic [2:0] {
    ST_INIT, ST_MODE_KEY, ST_MODE_GAP, ST_PARAM_KEY, ST_ADDR, ST_DONE, ST_FAULT
  } seqState_t;

  localparam logic [1:0] MODE_NONE = 2'd0;
  localparam logic [1:0] MODE_BLOW = 2'd1;
  localparam logic [1:0] MODE_TRY  = 2'd2;
  localparam logic [1:0] MODE_READ = 2'd3;

  localparam int KEY_MODES     = 3;
  localparam int KEY_REGS      = 4;
  localparam int READ_ONLY_REG = 3;
  // key counter holds up to KEY_REGS plus an overflow code
  localparam int KEY_W         = $clog2(KEY_REGS + 2);

  typedef struct packed {
    logic       enterAddr;
    logic       stepMid;
    logic [1:0] mode;
    logic [1:0] regIdx;
  } dpStrobe_t;
endpackage

// File: rtl/trimSeqCtrl.sv
module trimSeqCtrl
  import trimSeqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             midPulse,
  input  logic             highPulse,
  input  logic             blowPulse,
  input  logic             lockFuse,
  output dpStrobe_t        strobe,
  output logic [1:0]       selMode,
  output logic [KEY_W-1:0] selReg,
  output logic             blowReq,
  output logic             faultIdle,
  output logic             readPhase,
  output logic             inAddr
);
  localparam logic [KEY_W-1:0] CNT_MAX = '1;

  seqState_t        state, stNext;
  logic [KEY_W-1:0] keyCnt, cntNext, regNext;
  logic [1:0]       modeNext;
  logic             reqNext, enter, step;
  logic             modeKeyOk, regKeyOk;

  assign modeKeyOk = (keyCnt != '0) && (keyCnt <= KEY_W'(KEY_MODES));
  assign regKeyOk  = (keyCnt != '0) && (keyCnt <= KEY_W'(KEY_REGS)) &&
                     ((keyCnt != KEY_W'(READ_ONLY_REG)) || (selMode == MODE_READ));

  always_comb begin
    stNext   = state;
    cntNext  = keyCnt;
    modeNext = selMode;
    regNext  = selReg;
    reqNext  = 1'b0;
    enter    = 1'b0;
    step     = 1'b0;
    case (state)
      ST_INIT: if (highPulse) begin
        stNext  = ST_MODE_KEY;
        cntNext = '0;
      end
      ST_MODE_KEY: begin
        if (highPulse) begin
          if (modeKeyOk) begin
            stNext   = ST_MODE_GAP;
            modeNext = keyCnt[1:0];
          end else begin
            stNext = ST_FAULT;
          end
        end else if (midPulse && keyCnt != CNT_MAX) begin
          cntNext = keyCnt + 1'b1;
        end
      end
      ST_MODE_GAP: begin
        if (highPulse) begin
          stNext  = ST_PARAM_KEY;
          cntNext = '0;
        end else if (midPulse) begin
          stNext = ST_FAULT;
        end
      end
      ST_PARAM_KEY: begin
        if (highPulse) begin
          if (regKeyOk) begin
            stNext  = ST_ADDR;
            regNext = keyCnt;
            enter   = 1'b1;
          end else begin
            stNext = ST_FAULT;
          end
        end else if (midPulse && keyCnt != CNT_MAX) begin
          cntNext = keyCnt + 1'b1;
        end
      end
      ST_ADDR: begin
        if (selMode == MODE_BLOW && blowPulse) begin
          reqNext = ~lockFuse;
          stNext  = ST_DONE;
        end else if (highPulse) begin
          stNext  = ST_PARAM_KEY;
          cntNext = '0;
        end else if (midPulse) begin
          step = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_INIT;
      keyCnt  <= '0;
      selMode <= MODE_NONE;
      selReg  <= '0;
      blowReq <= 1'b0;
    end else begin
      state   <= stNext;
      keyCnt  <= cntNext;
      selMode <= modeNext;
      selReg  <= regNext;
      blowReq <= reqNext;
    end
  end

  assign strobe.enterAddr = enter;
  assign strobe.stepMid   = step;
  assign strobe.mode      = selMode;
  assign strobe.regIdx    = selReg[1:0] - 2'd1;

  assign faultIdle = (state == ST_FAULT);
  assign inAddr    = (state == ST_ADDR);
  assign readPhase = (selMode == MODE_READ) &&
                     (state == ST_MODE_GAP || state == ST_PARAM_KEY || state == ST_ADDR);
endmodule

// File: rtl/trimSeqData.sv
module trimSeqData
  import trimSeqPkg::*;
#(
  parameter int CODE_W    = 7,
  parameter int BLOW_W    = 9,
  parameter int READ_BITS = 9,
  parameter int PTR_W     = $clog2(READ_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              inAddr,
  input  logic              readPhase,
  input  logic              fuseBit,
  output logic [CODE_W-1:0] tryCode,
  output logic [BLOW_W-1:0] blowAddr,
  output logic [PTR_W-1:0]  readPtr,
  output logic              readValid,
  output logic [1:0]        readLevel
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(READ_BITS - 1);

  logic [CODE_W-1:0] tryVal [KEY_REGS];
  logic [BLOW_W-1:0] oneHot;
  logic [PTR_W-1:0]  ptr;

  for (genvar g = 0; g < KEY_REGS; g++) begin : gTry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tryVal[g] <= '0;
      end else if (strobe.stepMid && strobe.mode == MODE_TRY &&
                   strobe.regIdx == 2'(g) && tryVal[g] != '1) begin
        tryVal[g] <= tryVal[g] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oneHot <= BLOW_W'(1);
      ptr    <= '0;
    end else if (strobe.enterAddr) begin
      oneHot <= BLOW_W'(1);
      ptr    <= '0;
    end else if (strobe.stepMid) begin
      if (strobe.mode == MODE_BLOW && !oneHot[BLOW_W-1]) oneHot <= oneHot << 1;
      if (strobe.mode == MODE_READ && ptr != PTR_LAST)   ptr    <= ptr + 1'b1;
    end
  end

  assign tryCode   = tryVal[strobe.regIdx];
  assign blowAddr  = (inAddr && strobe.mode == MODE_BLOW) ? oneHot : '0;
  assign readPtr   = ptr;
  assign readValid = inAddr && (strobe.mode == MODE_READ);
  assign readLevel = !readPhase ? 2'd0 : (inAddr ? {fuseBit, 1'b0} : 2'd1);
endmodule

// File: rtl/trimProgSeq.sv
module trimProgSeq
  import trimSeqPkg::*;
#(
  parameter  int CODE_W    = 7,
  parameter  int BLOW_W    = 9,
  parameter  int READ_BITS = 9,
  localparam int PTR_W     = $clog2(READ_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              midPulse,
  input  logic              highPulse,
  input  logic              blowPulse,
  input  logic              lockFuse,
  input  logic              fuseBit,
  output logic [1:0]        selMode,
  output logic [2:0]        selReg,
  output logic [CODE_W-1:0] tryCode,
  output logic [BLOW_W-1:0] blowAddr,
  output logic [PTR_W-1:0]  readPtr,
  output logic              readValid,
  output logic [1:0]        readLevel,
  output logic              blowReq,
  output logic              faultIdle
);
  dpStrobe_t strobe;
  logic      readPhase, inAddr;

  trimSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .midPulse(midPulse), .highPulse(highPulse),
    .blowPulse(blowPulse), .lockFuse(lockFuse), .strobe(strobe),
    .selMode(selMode), .selReg(selReg), .blowReq(blowReq),
    .faultIdle(faultIdle), .readPhase(readPhase), .inAddr(inAddr)
  );

  trimSeqData #(.CODE_W(CODE_W), .BLOW_W(BLOW_W), .READ_BITS(READ_BITS), .PTR_W(PTR_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inAddr(inAddr),
    .readPhase(readPhase), .fuseBit(fuseBit), .tryCode(tryCode),
    .blowAddr(blowAddr), .readPtr(readPtr), .readValid(readValid),
    .readLevel(readLevel)
  );
endmodule

// File: rtl/trimProgSeqChk.sv
module trimProgSeqChk #(
  parameter int CODE_W    = 7,
  parameter int BLOW_W    = 9,
  parameter int READ_BITS = 9,
  parameter int PTR_W     = $clog2(READ_BITS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              blowPulse,
  input logic              lockFuse,
  input logic [1:0]        selMode,
  input logic [BLOW_W-1:0] blowAddr,
  input logic [PTR_W-1:0]  readPtr,
  input logic              readValid,
  input logic [1:0]        readLevel,
  input logic              blowReq,
  input logic              faultIdle
);
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(blowAddr));
  a_r5_blow_only: assert property (@(posedge clk) disable iff (!rstN)
    (blowAddr != '0) |-> (selMode == 2'd1));
  a_r6_cause: assert property (@(posedge clk) disable iff (!rstN)
    blowReq |-> $past(blowPulse));
  a_r6_single: assert property (@(posedge clk) disable iff (!rstN)
    blowReq |=> (!blowReq && blowAddr == '0));
  a_r7_lock: assert property (@(posedge clk) disable iff (!rstN)
    blowReq |-> !$past(lockFuse));
  a_r8_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(readPtr) <= READ_BITS - 1);
  a_r9_level: assert property (@(posedge clk) disable iff (!rstN)
    readLevel != 2'd3);
  a_r9_valid_mode: assert property (@(posedge clk) disable iff (!rstN)
    readValid |-> (selMode == 2'd3));
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    faultIdle |=> faultIdle);
endmodule

bind trimProgSeq trimProgSeqChk #(
  .CODE_W(CODE_W), .BLOW_W(BLOW_W), .READ_BITS(READ_BITS), .PTR_W(PTR_W)
) chk (.*);

// File: tb/tb_trimProgSeq.sv
`timescale 1ns/1ps
module tb_trimProgSeq;
  localparam int CODE_W    = 3;
  localparam int BLOW_W    = 4;
  localparam int READ_BITS = 5;
  localparam int PTR_W     = $clog2(READ_BITS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic midPulse = 1'b0, highPulse = 1'b0, blowPulse = 1'b0, lockFuse = 1'b0;
  logic fuseBit;
  logic [1:0]        selMode, readLevel;
  logic [2:0]        selReg;
  logic [CODE_W-1:0] tryCode;
  logic [BLOW_W-1:0] blowAddr;
  logic [PTR_W-1:0]  readPtr;
  logic              readValid, blowReq, faultIdle;

  logic [READ_BITS-1:0] fuseMap = 5'b10110;
  assign fuseBit = (int'(readPtr) < READ_BITS) ? fuseMap[readPtr] : 1'b0;

  always #2.5 clk = ~clk;

  trimProgSeq #(.CODE_W(CODE_W), .BLOW_W(BLOW_W), .READ_BITS(READ_BITS)) dut (.*);

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural reference: phase 0 init,1 mode key,2 gap,3 param key,4 addr,5 done,6 fault
  int mPhase, mCnt, mMode, mReg, mOne, mPtr;
  int mTry [1:4];
  bit mReq;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mMode = 0; mReg = 0; mOne = 0; mPtr = 0; mReq = 0;
      for (int i = 1; i <= 4; i++) mTry[i] = 0;
    end else begin
      mReq = 0;
      case (mPhase)
        0: if (highPulse) begin mPhase = 1; mCnt = 0; end
        1: if (highPulse) begin
             if (mCnt >= 1 && mCnt <= 3) begin mMode = mCnt; mPhase = 2; end
             else mPhase = 6;
           end else if (midPulse) mCnt++;
        2: if (highPulse) begin mPhase = 3; mCnt = 0; end
           else if (midPulse) mPhase = 6;
        3: if (highPulse) begin
             if (mCnt >= 1 && mCnt <= 4 && (mCnt != 3 || mMode == 3)) begin
               mReg = mCnt; mPhase = 4; mOne = 0; mPtr = 0;
             end else mPhase = 6;
           end else if (midPulse) mCnt++;
        4: if (mMode == 1 && blowPulse) begin mReq = !lockFuse; mPhase = 5; end
           else if (highPulse) begin mPhase = 3; mCnt = 0; end
           else if (midPulse) begin
             if (mMode == 1 && mOne < BLOW_W - 1) mOne++;
             if (mMode == 2 && mTry[mReg] < (1 << CODE_W) - 1) mTry[mReg]++;
             if (mMode == 3 && mPtr < READ_BITS - 1) mPtr++;
           end
        default: ;
      endcase
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      cmp("R2 selMode", selMode, mMode);
      cmp("R3 selReg", selReg, mReg);
      cmp("R4 tryCode", tryCode, (mReg == 0) ? 0 : mTry[mReg]);
      cmp("R5 blowAddr", blowAddr, (mPhase == 4 && mMode == 1) ? (1 << mOne) : 0);
      cmp("R8 readPtr", readPtr, mPtr);
      cmp("R8 readValid", readValid, (mPhase == 4 && mMode == 3) ? 1 : 0);
      cmp("R9 readLevel", readLevel,
          (mMode == 3 && mPhase >= 2 && mPhase <= 4) ?
          ((mPhase == 4) ? (fuseMap[mPtr] ? 2 : 0) : 1) : 0);
      cmp("R6 blowReq", blowReq, mReq);
      cmp("R11 faultIdle", faultIdle, (mPhase == 6) ? 1 : 0);
    end
  end

  task automatic doReset();
    @(posedge clk); #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic mid(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 midPulse = 1'b1;
      @(posedge clk); #1 midPulse = 1'b0;
    end
  endtask

  task automatic high(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 highPulse = 1'b1;
      @(posedge clk); #1 highPulse = 1'b0;
    end
  endtask

  task automatic blow();
    @(posedge clk); #1 blowPulse = 1'b1;
    @(posedge clk); #1 blowPulse = 1'b0;
  endtask

  task automatic pickMode(input int m);
    high(1); mid(m); high(2);
  endtask

  task automatic pickReg(input int r);
    mid(r); high(1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    doReset();
    @(negedge clk);
    cmp("R1 reset selMode", selMode, 0);
    cmp("R1 reset faultIdle", faultIdle, 0);
    cmp("R1 reset blowAddr", blowAddr, 0);
    cmp("R1 reset readLevel", readLevel, 0);

    // try mode, with mids ignored before the first high pulse
    mid(3);
    pickMode(2);
    @(negedge clk); cmp("R1 R2 try mode chosen", selMode, 2);
    pickReg(1);
    mid(9);
    @(negedge clk); cmp("R4 try saturates", tryCode, 7);
    high(1); pickReg(2); mid(2);
    @(negedge clk); cmp("R3 reg2 selected", selReg, 2);
    cmp("R4 reg2 code", tryCode, 2);
    high(1); pickReg(1);
    @(negedge clk); cmp("R4 reg1 value kept", tryCode, 7);
    high(1); pickReg(4); mid(1);
    @(negedge clk); cmp("R3 reg4 selected", selReg, 4);

    // blow mode
    doReset();
    pickMode(1); pickReg(2);
    @(negedge clk); cmp("R5 start bit0", blowAddr, 1);
    mid(5);
    @(negedge clk); cmp("R5 saturate msb", blowAddr, 8);
    high(1); pickReg(1);
    @(negedge clk); cmp("R5 reentry bit0", blowAddr, 1);
    mid(1);
    blow();
    @(negedge clk); cmp("R6 blow request", blowReq, 1);
    high(1); mid(2); blow();
    @(negedge clk); cmp("R6 ignored after blow", blowAddr, 0);
    cmp("R6 no second request", blowReq, 0);
    cmp("R6 register unchanged", selReg, 1);

    // locked device: blow suppressed, read still works
    lockFuse = 1'b1;
    doReset();
    pickMode(1); pickReg(1); blow();
    @(negedge clk); cmp("R7 lock suppresses", blowReq, 0);
    doReset();
    pickMode(3);
    @(negedge clk); cmp("R9 read selected level", readLevel, 1);
    pickReg(3);
    @(negedge clk); cmp("R8 pointer at bit0", readPtr, 0);
    cmp("R9 intact fuse level", readLevel, 0);
    mid(2);
    @(negedge clk); cmp("R8 pointer at bit2", readPtr, 2);
    cmp("R9 blown fuse level", readLevel, 2);
    mid(6);
    @(negedge clk); cmp("R8 pointer saturates", readPtr, READ_BITS - 1);
    lockFuse = 1'b0;

    // fault paths
    doReset();
    pickMode(2); pickReg(3);
    @(negedge clk); cmp("R10 reg3 outside read", faultIdle, 1);
    high(1); mid(1); high(1);
    @(negedge clk); cmp("R11 fault holds", faultIdle, 1);
    doReset();
    @(negedge clk); cmp("R11 reset clears fault", faultIdle, 0);
    high(2);
    @(negedge clk); cmp("R11 zero mode count", faultIdle, 1);
    doReset(); high(1); mid(4); high(1);
    @(negedge clk); cmp("R11 mode count too big", faultIdle, 1);
    doReset(); pickMode(2); pickReg(5);
    @(negedge clk); cmp("R11 register count too big", faultIdle, 1);
    doReset(); high(1); mid(1); high(1); mid(1);
    @(negedge clk); cmp("R11 mid in gap", faultIdle, 1);

    repeat (3) @(posedge clk);
    @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule